// File: doc/BRIEF.md
# Nested Spill/Event/Module Stream Grammar Checker

This block sits in line on a stream of 32-bit acquisition words and checks that the stream follows a three-level nested framing. The outermost level is a spill, which holds zero or more events. An event holds module blocks. A module block holds payload words. The top four bits of every word pick its class, and the low 28 bits carry the payload.

A nesting state machine follows the current level. It reports each word that arrives where the grammar does not allow it. After such a fault it ignores everything up to the next spill header and then starts again.

Every accepted word is passed on through a single registered output stage, together with its decoded class and a per-word error vector. A sticky error vector collects every fault seen since reset. The block also presents the fields taken from the most recent legal headers: event number, slot number, module identifier and spill type. It does not verify checksums, and it does not decode module-specific payloads.

Back-pressure follows the valid/ready rules. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and all of its side information stay unchanged.

Top module: `daq_frame_checker`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A word accepted at an edge appears on `out_word` with `out_valid` high right after that edge. While the output is stalled (`out_valid` high and `out_ready` low), the output stays unchanged.
- R2: `out_kind` equals 0 for type codes 0x0 to 0x7 (payload word). For codes 0x8 to 0xF it equals the code: 8 module open, 9 module close, A event open, B event close, C spill open, D spill close, E status, F padding.
- R3: A correctly nested stream produces an all-zero `out_err` on every word. Payload words are legal only inside a module. Module open and close are legal only inside an event. Event open and close are legal only inside a spill. Spill open is legal only outside a spill.
- R4: A payload word outside a module block sets `out_err` bit 0.
- R5: A header that is not legal at the current level sets `out_err` bit 1. This covers a header for a level that is already open and a header that skips a level.
- R6: A close word that does not match the innermost open level sets `out_err` bit 2.
- R7: After a fault on bit 0, 1 or 2, every word except a spill open is ignored and flags nothing. The next spill open starts a new spill.
- R8: Status (0xE) and padding (0xF) words are accepted at any level, raise no error and leave the nesting level unchanged.
- R9: A legal event open loads `evt_num` from bits [19:0]. A legal module open loads `slot_num` from bits [27:23] and `module_id` from bits [22:16]. A legal spill open loads `spill_type` from bit 27. Each field updates at the same edge that presents the word on the output.
- R10: A legal module open whose bits [15:0] differ from `evt_num[15:0]` sets `out_err` bit 3, and the module is still opened.
- R11: A spill close whose bit 27 differs from `spill_type` sets `out_err` bit 4, and the spill is still closed.
- R12: After reset `out_valid` and `err_sticky` are 0. `err_sticky` is the OR of every `out_err` pulse since reset and never clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be accepted |
| in_word | input | 32 | Input word, type in [31:28] |
| out_ready | input | 1 | Downstream can take the output word |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Forwarded word |
| out_kind | output | 4 | Decoded class of the output word |
| out_err | output | 5 | Faults raised by the output word |
| err_sticky | output | 5 | Accumulated faults since reset |
| evt_num | output | 20 | Event number from the last legal event open |
| slot_num | output | 5 | Slot number from the last legal module open |
| module_id | output | 7 | Module identifier from the last legal module open |
| spill_type | output | 1 | Spill type from the last legal spill open |

## Verification
Every result depends on one register stage. The class, the error vector, the sticky vector and the captured fields of a word are all due at the clock edge that accepts the word. The bench drives each word on a falling edge and reads all results on the next falling edge, which lies half a period after the accepting edge. The stall test holds `out_ready` low over several falling edges, checks that the word and `in_ready` do not move, and then confirms that the queued word takes the output slot one edge after `out_ready` rises.

// File: rtl/daq_frame_pkg.sv
package daq_frame_pkg;
  localparam int TYPE_W = 4;
  localparam int ERR_W  = 5;

  typedef enum logic [TYPE_W-1:0] {
    K_DATA = 4'h0,
    K_MHDR = 4'h8,
    K_MTRL = 4'h9,
    K_EHDR = 4'hA,
    K_ETRL = 4'hB,
    K_SHDR = 4'hC,
    K_STRL = 4'hD,
    K_STAT = 4'hE,
    K_PADD = 4'hF
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SPILL,
    S_EVENT,
    S_MODULE,
    S_HUNT
  } level_t;

  localparam int E_STRAY = 0;
  localparam int E_HDR   = 1;
  localparam int E_TRL   = 2;
  localparam int E_EVN   = 3;
  localparam int E_SPT   = 4;
endpackage

// File: rtl/daq_word_classify.sv
module daq_word_classify
  import daq_frame_pkg::*;
(
  input  logic [TYPE_W-1:0] type_code,
  output kind_t             kind,
  output logic              is_hdr,
  output logic              is_trl,
  output logic              is_side
);
  always_comb begin
    if (!type_code[TYPE_W-1]) kind = K_DATA;
    else                      kind = kind_t'(type_code);
  end

  always_comb begin
    is_hdr  = 1'b0;
    is_trl  = 1'b0;
    is_side = 1'b0;
    unique case (kind)
      K_MHDR, K_EHDR, K_SHDR: is_hdr  = 1'b1;
      K_MTRL, K_ETRL, K_STRL: is_trl  = 1'b1;
      K_STAT, K_PADD:         is_side = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/daq_field_track.sv
module daq_field_track #(
  parameter int PAY_W  = 28,
  parameter int EVN_W  = 20,
  parameter int MEVN_W = 16,
  parameter int SLOT_W = 5,
  parameter int MID_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAY_W-1:0]  payload,
  input  logic              load_spill,
  input  logic              load_event,
  input  logic              load_module,
  output logic              evn_mis,
  output logic              spt_mis,
  output logic [EVN_W-1:0]  evt_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [MID_W-1:0]  mid_q,
  output logic              spt_q
);
  localparam int SPT_BIT  = PAY_W - 1;
  localparam int SLOT_LSB = PAY_W - SLOT_W;
  localparam int MID_LSB  = SLOT_LSB - MID_W;

  assign evn_mis = payload[MEVN_W-1:0] != evt_q[MEVN_W-1:0];
  assign spt_mis = payload[SPT_BIT] != spt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      slot_q <= '0;
      mid_q  <= '0;
      spt_q  <= 1'b0;
    end else begin
      if (load_event)  evt_q <= payload[EVN_W-1:0];
      if (load_spill)  spt_q <= payload[SPT_BIT];
      if (load_module) begin
        slot_q <= payload[SLOT_LSB +: SLOT_W];
        mid_q  <= payload[MID_LSB +: MID_W];
      end
    end
  end

  p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_module |=> $stable(slot_q) && $stable(mid_q));
  p_evt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_event |=> $stable(evt_q));
endmodule

// File: rtl/daq_nest_fsm.sv
module daq_nest_fsm
  import daq_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  kind_t            kind,
  input  logic             is_hdr,
  input  logic             is_trl,
  input  logic             is_side,
  input  logic             evn_mis,
  input  logic             spt_mis,
  output logic             open_spill,
  output logic             open_event,
  output logic             open_module,
  output logic [ERR_W-1:0] err
);
  level_t st, nxt;
  logic   bad;

  always_comb begin
    nxt         = st;
    err         = '0;
    bad         = 1'b0;
    open_spill  = 1'b0;
    open_event  = 1'b0;
    open_module = 1'b0;
    if (!is_side) begin
      unique case (st)
        S_HUNT: begin
          if (kind == K_SHDR) begin
            nxt        = S_SPILL;
            open_spill = 1'b1;
          end
        end
        S_IDLE: begin
          if (kind == K_SHDR) begin
            nxt        = S_SPILL;
            open_spill = 1'b1;
          end else bad = 1'b1;
        end
        S_SPILL: begin
          if (kind == K_EHDR) begin
            nxt        = S_EVENT;
            open_event = 1'b1;
          end else if (kind == K_STRL) begin
            nxt        = S_IDLE;
            err[E_SPT] = spt_mis;
          end else bad = 1'b1;
        end
        S_EVENT: begin
          if (kind == K_MHDR) begin
            nxt         = S_MODULE;
            open_module = 1'b1;
            err[E_EVN]  = evn_mis;
          end else if (kind == K_ETRL) begin
            nxt = S_SPILL;
          end else bad = 1'b1;
        end
        S_MODULE: begin
          if (kind == K_MTRL) nxt = S_EVENT;
          else if (kind != K_DATA) bad = 1'b1;
        end
        default: nxt = S_HUNT;
      endcase
    end
    if (bad) begin
      nxt          = S_HUNT;
      err[E_STRAY] = (kind == K_DATA);
      err[E_HDR]   = is_hdr;
      err[E_TRL]   = is_trl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   st <= S_IDLE;
    else if (acc) st <= nxt;
  end

  p_hunt_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HUNT && acc && kind != K_SHDR) |=> st == S_HUNT);
  p_side_no_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_side) |=> $stable(st));
  p_module_from_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MODULE && $past(st) != S_MODULE) |-> $past(st) == S_EVENT);
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> $onehot0(err));
endmodule

// File: rtl/daq_frame_checker.sv
module daq_frame_checker
  import daq_frame_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EVN_W  = 20,
  parameter int MEVN_W = 16,
  parameter int SLOT_W = 5,
  parameter int MID_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [TYPE_W-1:0] out_kind,
  output logic [ERR_W-1:0]  out_err,
  output logic [ERR_W-1:0]  err_sticky,
  output logic [EVN_W-1:0]  evt_num,
  output logic [SLOT_W-1:0] slot_num,
  output logic [MID_W-1:0]  module_id,
  output logic              spill_type
);
  localparam int PAY_W = WORD_W - TYPE_W;

  logic             acc;
  kind_t            kind;
  logic             is_hdr, is_trl, is_side;
  logic             evn_mis, spt_mis;
  logic             open_spill, open_event, open_module;
  logic [ERR_W-1:0] err_now;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  daq_word_classify u_class (
    .type_code (in_word[WORD_W-1 -: TYPE_W]),
    .kind      (kind),
    .is_hdr    (is_hdr),
    .is_trl    (is_trl),
    .is_side   (is_side)
  );

  daq_field_track #(
    .PAY_W (PAY_W), .EVN_W (EVN_W), .MEVN_W (MEVN_W),
    .SLOT_W(SLOT_W), .MID_W (MID_W)
  ) u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .payload     (in_word[PAY_W-1:0]),
    .load_spill  (acc && open_spill),
    .load_event  (acc && open_event),
    .load_module (acc && open_module),
    .evn_mis     (evn_mis),
    .spt_mis     (spt_mis),
    .evt_q       (evt_num),
    .slot_q      (slot_num),
    .mid_q       (module_id),
    .spt_q       (spill_type)
  );

  daq_nest_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .kind        (kind),
    .is_hdr      (is_hdr),
    .is_trl      (is_trl),
    .is_side     (is_side),
    .evn_mis     (evn_mis),
    .spt_mis     (spt_mis),
    .open_spill  (open_spill),
    .open_event  (open_event),
    .open_module (open_module),
    .err         (err_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      out_kind   <= '0;
      out_err    <= '0;
      err_sticky <= '0;
    end else begin
      if (acc) begin
        out_valid  <= 1'b1;
        out_word   <= in_word;
        out_kind   <= kind;
        out_err    <= err_now;
        err_sticky <= err_sticky | err_now;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_err   <= '0;
      end
    end
  end

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_word) && $stable(out_err));
  p_stall_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_sticky_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_sticky & $past(err_sticky)) == $past(err_sticky));
  p_err_in_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (err_sticky & out_err) == out_err);
endmodule

// File: tb/daq_frame_checker_bench.sv
module daq_frame_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [31:0] out_word;
  logic [3:0]  out_kind;
  logic [4:0]  out_err;
  logic [4:0]  err_sticky;
  logic [19:0] evt_num;
  logic [4:0]  slot_num;
  logic [6:0]  module_id;
  logic        spill_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  daq_frame_checker u_daq_frame_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_ready(out_ready), .out_valid(out_valid),
    .out_word(out_word), .out_kind(out_kind), .out_err(out_err),
    .err_sticky(err_sticky), .evt_num(evt_num), .slot_num(slot_num),
    .module_id(module_id), .spill_type(spill_type)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] t, input logic [27:0] p);
    return {t, p};
  endfunction

  function automatic logic [31:0] mhdr(input logic [4:0] s, input logic [6:0] m, input logic [15:0] e);
    return {4'h8, s, m, e};
  endfunction

  // drive one word, then read its class and fault vector one edge later
  task automatic send(input logic [31:0] w, input logic [3:0] ek, input logic [4:0] ee, input string tag);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid R1"}, 32'(out_valid), 32'd1);
    chk({tag, " word R1"}, out_word, w);
    chk({tag, " kind R2"}, 32'(out_kind), 32'(ek));
    chk({tag, " err"}, 32'(out_err), 32'(ee));
  endtask

  task automatic t_reset;
    chk("reset out_valid R12", 32'(out_valid), 32'd0);
    chk("reset sticky R12", 32'(err_sticky), 32'd0);
    chk("reset in_ready R1", 32'(in_ready), 32'd1);
  endtask

  task automatic t_stall;
    out_ready = 1'b0;
    @(negedge clk);
    in_word = mk(4'hE, 28'h1000001); in_valid = 1'b1;
    @(negedge clk);
    in_word = mk(4'hF, 28'hFFFFFFF);
    chk("stall in_ready low R1", 32'(in_ready), 32'd0);
    chk("stall first word R1", out_word, mk(4'hE, 28'h1000001));
    @(negedge clk);
    chk("stall word held R1", out_word, mk(4'hE, 28'h1000001));
    chk("stall still low R1", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("stall release R1", out_word, mk(4'hF, 28'hFFFFFFF));
    chk("stall release kind R8", 32'(out_kind), 32'hF);
    chk("stall no err R8", 32'(out_err), 32'd0);
  endtask

  task automatic t_legal;
    send(mk(4'hC, 28'h0), 4'hC, 5'h0, "legal spill open R3");
    chk("spill type R9", 32'(spill_type), 32'd0);
    send(mk(4'hF, 28'hFFFFFFF), 4'hF, 5'h0, "padding in spill R8");
    send(mk(4'hA, 28'h0012345), 4'hA, 5'h0, "event open R3");
    chk("event number R9", 32'(evt_num), 32'h12345);
    send(mhdr(5'd3, 7'd5, 16'h2345), 4'h8, 5'h0, "module open R10");
    chk("slot R9", 32'(slot_num), 32'd3);
    chk("module id R9", 32'(module_id), 32'd5);
    send(mk(4'h1, 28'hABCDEF0), 4'h0, 5'h0, "data code1 R2");
    send(mk(4'hE, 28'h1000100), 4'hE, 5'h0, "status in module R8");
    send(mk(4'h7, 28'h0000001), 4'h0, 5'h0, "data code7 R2");
    send(mk(4'h9, 28'h0000003), 4'h9, 5'h0, "module close R3");
    send(mhdr(5'd9, 7'd100, 16'h2345), 4'h8, 5'h0, "empty module open R3");
    chk("slot second R9", 32'(slot_num), 32'd9);
    chk("module id second R9", 32'(module_id), 32'd100);
    send(mk(4'h9, 28'h0), 4'h9, 5'h0, "empty module close R3");
    send(mk(4'hB, 28'h0), 4'hB, 5'h0, "event close R3");
    send(mk(4'hD, 28'h0), 4'hD, 5'h0, "spill close R3");
    send(mk(4'hE, 28'h0), 4'hE, 5'h0, "status outside spill R8");
    chk("legal sticky R12", 32'(err_sticky), 32'd0);
  endtask

  task automatic t_stray;
    send(mk(4'h3, 28'h5), 4'h0, 5'h01, "stray data R4");
    send(mk(4'hA, 28'h7), 4'hA, 5'h00, "hunt ignores event open R7");
    send(mk(4'h9, 28'h0), 4'h9, 5'h00, "hunt ignores close R7");
    chk("event number unchanged in hunt R7", 32'(evt_num), 32'h12345);
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "hunt spill resync R7");
    send(mk(4'hA, 28'h00001), 4'hA, 5'h00, "event open after resync R7");
    send(mk(4'hB, 28'h0), 4'hB, 5'h00, "event close R3");
    send(mk(4'hD, 28'h0), 4'hD, 5'h00, "spill close R3");
  endtask

  task automatic t_dup_hdr;
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "spill open R3");
    send(mk(4'hA, 28'h2), 4'hA, 5'h00, "event open R3");
    send(mk(4'hA, 28'h3), 4'hA, 5'h02, "duplicate event open R5");
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "resync R7");
    send(mhdr(5'd1, 7'd1, 16'h2), 4'h8, 5'h02, "module open skipping level R5");
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "resync again R7");
    send(mk(4'hD, 28'h0), 4'hD, 5'h00, "spill close R3");
  endtask

  task automatic t_trl;
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "spill open R3");
    send(mk(4'hA, 28'h4), 4'hA, 5'h00, "event open R3");
    send(mhdr(5'd2, 7'd2, 16'h4), 4'h8, 5'h00, "module open R3");
    send(mk(4'hB, 28'h0), 4'hB, 5'h04, "event close inside module R6");
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "resync R7");
    send(mk(4'hD, 28'h0), 4'hD, 5'h00, "spill close R3");
    send(mk(4'h9, 28'h0), 4'h9, 5'h04, "module close outside spill R6");
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "resync R7");
    send(mk(4'hD, 28'h0), 4'hD, 5'h00, "spill close R3");
  endtask

  task automatic t_evn;
    send(mk(4'hC, 28'h0), 4'hC, 5'h00, "spill open R3");
    send(mk(4'hA, 28'h0ABCD), 4'hA, 5'h00, "event open R9");
    send(mhdr(5'd4, 7'd6, 16'h1234), 4'h8, 5'h08, "event number mismatch R10");
    chk("mismatch still loads slot R10", 32'(slot_num), 32'd4);
    send(mk(4'h2, 28'h1), 4'h0, 5'h00, "data after mismatch open R10");
    send(mk(4'h9, 28'h0), 4'h9, 5'h00, "module close R10");
    send(mhdr(5'd4, 7'd6, 16'hABCD), 4'h8, 5'h00, "matching module open R10");
    send(mk(4'h9, 28'h0), 4'h9, 5'h00, "module close R3");
    send(mk(4'hB, 28'h0), 4'hB, 5'h00, "event close R3");
    send(mk(4'hD, 28'h0), 4'hD, 5'h00, "spill close R3");
  endtask

  task automatic t_spt;
    send(mk(4'hC, 28'h8000000), 4'hC, 5'h00, "end-of-spill open R9");
    chk("spill type one R9", 32'(spill_type), 32'd1);
    send(mk(4'hD, 28'h0), 4'hD, 5'h10, "spill type mismatch R11");
    send(mk(4'hC, 28'h8000000), 4'hC, 5'h00, "spill closed after mismatch R11");
    send(mk(4'hD, 28'h8000000), 4'hD, 5'h00, "matching spill close R11");
    chk("sticky all faults R12", 32'(err_sticky), 32'h1F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stall();
    t_legal();
    t_stray();
    t_dup_hdr();
    t_trl();
    t_evn();
    t_spt();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule